// File: doc/BRIEF.md
# Grouped Shadow Compare Latch Bank

This block holds a bank of compare channels for a timer. Each channel has a compare register that software writes, plus a shadow latch that software cannot reach. The timer counter is compared only against the shadow latch. The latch takes its register's value only at a load event. This lets software rewrite a compare value at any time without disturbing the period or duty cycle that is currently running.

Each channel has a two-bit load mode that picks its load event. The events are: at once on a write, when the counter reaches zero, when the counter reaches the channel-0 latch value, or a choice between the last two that depends on the count mode. A two-bit grouping field can tie channels into pairs, triples or one whole group. Every latch in a group then loads on the event chosen by the group's lead channel. Each latch takes its own register's value, so several compare values change in the same cycle.

The block does not generate the counter and has no capture logic. The counter value, the count mode and the direction come in as plain inputs. There is no stream data path, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `cmp_latch_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register and every latch reads 0 until it is loaded.
- R2: `eq_hit[i]` is 1 in the same cycle exactly when `cnt_val` equals latch i. It never reflects the value in the written register.
- R3: Effective load mode 2'b00 loads the latch with the written data at the same clock edge that writes the register.
- R4: Mode 2'b01 loads at the edge that ends the first cycle in which `cnt_val` is 0. A cycle with `cnt_val` at 0 fires the event only if the previous cycle had `cnt_val` nonzero. The cycle after reset counts as having been at 0, so a counter held at 0 after reset fires no event. A counter held at 0 fires no further event, and a write made while the counter is held at 0 stays in the register only.
- R5: Mode 2'b10 uses the zero event of R4 when `cnt_mode` is not 2'b11. When `cnt_mode` is 2'b11 (up/down) it uses the top event of R6, but only while `cnt_dn` is 0.
- R6: Mode 2'b11 loads at the edge that ends the first cycle in which `cnt_val` equals latch 0. As in R4, the cycle after reset counts as already matching, and a value that is held fires no further event.
- R7: With `grp_sel` 2'b00 each channel uses its own load mode. With 2'b01 channels {1,2}, {3,4} and {5,6} form pairs, each using the mode of its lower channel, and channel 0 stays alone.
- R8: With `grp_sel` 2'b10 the triples {1,2,3} and {4,5,6} use the modes of channels 1 and 4. With 2'b11 all channels 0 to 6 use the mode of channel 1.
- R9: On a group load event, every member latch takes its own register value in the same cycle, whichever registers were written. A member with no new write reloads its unchanged value.
- R10: A register write in the same cycle as a load event for that channel is captured by that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NCH | Per-channel compare register write strobe |
| wr_data | input | NCH*CW | Write data; channel i uses bits [i*CW +: CW] |
| ld_mode | input | 2*NCH | Load mode; channel i uses bits [2*i +: 2] |
| grp_sel | input | 2 | Grouping select (R7, R8) |
| cnt_val | input | CW | Counter value |
| cnt_mode | input | 2 | Count mode; 2'b11 means up/down |
| cnt_dn | input | 1 | 1 while the counter is counting down |
| latch_val | output | NCH*CW | Shadow latch values, same packing as wr_data |
| eq_hit | output | NCH | Per-channel equality of counter and latch |

## Verification
`eq_hit` is combinational, so it is checked in the same cycle as the counter value that drives it. A latch load shows on `latch_val` one edge after the cycle that carries the write or the counter event. The bench therefore drives inputs on the falling edge and checks the outputs just before the next rising edge. Only after that check does it step its own reference model over that edge. Directed phases set up each load mode and grouping with known values. A long random phase then mixes writes, held counters and mode changes against the same model.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    LD_NOW   = 2'b00,
    LD_ZERO  = 2'b01,
    LD_SPLIT = 2'b10,
    LD_TOP   = 2'b11
  } ld_mode_e;

  localparam logic [1:0] CM_UPDOWN = 2'b11;

  // Lead channel of channel ch under grouping grp.
  function automatic int unsigned lead_of(int unsigned ch, logic [1:0] grp,
                                          int unsigned nch);
    int unsigned l;
    case (grp)
      2'b00:   l = ch;
      2'b01:   l = (ch == 0) ? 0 : ((ch - 1) / 2) * 2 + 1;
      2'b10:   l = (ch == 0) ? 0 : ((ch - 1) / 3) * 3 + 1;
      default: l = 1;
    endcase
    if (l >= nch) l = ch;
    return l;
  endfunction
endpackage

// File: rtl/cl_evt_gen.sv
module cl_evt_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] top_val,
  output logic          zero_p,
  output logic          top_p
);
  logic at_zero, at_top, zero_q, top_q;

  assign at_zero = (cnt_val == '0);
  assign at_top  = (cnt_val == top_val);

  // Flags start set so a counter parked at reset fires nothing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_q <= 1'b1;
      top_q  <= 1'b1;
    end else begin
      zero_q <= at_zero;
      top_q  <= at_top;
    end
  end

  assign zero_p = at_zero && !zero_q;
  assign top_p  = at_top && !top_q;
endmodule

// File: rtl/cl_chan.sv
module cl_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          imm,
  input  logic          load,
  input  logic [CW-1:0] cnt_val,
  output logic [CW-1:0] latch_q,
  output logic          eq
);
  logic [CW-1:0] ccr_q;
  logic          take;

  assign take = imm ? wr : load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_q   <= '0;
      latch_q <= '0;
    end else begin
      if (wr)   ccr_q   <= wdata;
      if (take) latch_q <= wr ? wdata : ccr_q;
    end
  end

  assign eq = (cnt_val == latch_q);
endmodule

// File: rtl/cmp_latch_bank.sv
module cmp_latch_bank
  import cl_pkg::*;
#(
  parameter int NCH = 7,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_en,
  input  logic [NCH*CW-1:0] wr_data,
  input  logic [2*NCH-1:0]  ld_mode,
  input  logic [1:0]        grp_sel,
  input  logic [CW-1:0]     cnt_val,
  input  logic [1:0]        cnt_mode,
  input  logic              cnt_dn,
  output logic [NCH*CW-1:0] latch_val,
  output logic [NCH-1:0]    eq_hit
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           zero_p, top_p, top_ok;
  logic [NCH-1:0] evt, ld, imm;

  cl_evt_gen #(.CW(CW)) u_evt (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val),
    .top_val(latch_val[CW-1:0]), .zero_p(zero_p), .top_p(top_p)
  );

  assign top_ok = (cnt_mode == CM_UPDOWN) && !cnt_dn;

  // Event each channel would request as a group lead.
  always_comb begin
    for (int j = 0; j < NCH; j++) begin
      case (ld_mode_e'(ld_mode[2*j +: 2]))
        LD_ZERO:  evt[j] = zero_p;
        LD_SPLIT: evt[j] = (cnt_mode == CM_UPDOWN) ? (top_p && top_ok) : zero_p;
        LD_TOP:   evt[j] = top_p;
        default:  evt[j] = 1'b0;
      endcase
    end
  end

  // Route the lead's event and mode to each member.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      logic [IW-1:0] l;
      l      = IW'(lead_of(i, grp_sel, NCH));
      ld[i]  = evt[l];
      imm[i] = (ld_mode[2*l +: 2] == LD_NOW);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cl_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en[g]), .wdata(wr_data[g*CW +: CW]),
      .imm(imm[g]), .load(ld[g]), .cnt_val(cnt_val),
      .latch_q(latch_val[g*CW +: CW]), .eq(eq_hit[g])
    );
  end
endmodule

// File: rtl/cl_chk.sv
module cl_chk #(
  parameter int NCH = 7,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    wr_en,
  input logic [NCH*CW-1:0] wr_data,
  input logic [2*NCH-1:0]  ld_mode,
  input logic [1:0]        grp_sel,
  input logic [CW-1:0]     cnt_val,
  input logic [1:0]        cnt_mode,
  input logic              cnt_dn,
  input logic [NCH*CW-1:0] latch_val,
  input logic [NCH-1:0]    eq_hit
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> latch_val == '0);

  a_r4_hold_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cnt_val) && $stable(latch_val) && $past(wr_en) == '0 && wr_en == '0)
    |=> $stable(latch_val));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r2_eq_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cnt_val) && $stable(latch_val[i*CW +: CW])) |-> $stable(eq_hit[i]));

    a_r3_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == 2'b00 && wr_en[i] && ld_mode[2*i +: 2] == 2'b00)
      |=> latch_val[i*CW +: CW] == $past(wr_data[i*CW +: CW]));

    a_r4_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grp_sel) == 2'b00 && $past(ld_mode[2*i +: 2]) == 2'b01 &&
       latch_val[i*CW +: CW] != $past(latch_val[i*CW +: CW]))
      |-> $past(cnt_val) == '0);

    a_r6_top_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grp_sel) == 2'b00 && $past(ld_mode[2*i +: 2]) == 2'b11 &&
       latch_val[i*CW +: CW] != $past(latch_val[i*CW +: CW]))
      |-> $past(cnt_val) == $past(latch_val[CW-1:0]));
  end
endmodule

bind cmp_latch_bank cl_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ld_mode(ld_mode), .grp_sel(grp_sel), .cnt_val(cnt_val),
  .cnt_mode(cnt_mode), .cnt_dn(cnt_dn), .latch_val(latch_val), .eq_hit(eq_hit)
);

// File: tb/sim_cmp_latch_bank.sv
module sim_cmp_latch_bank;
  localparam int CLK_P = 10;
  localparam int NCH = 7;
  localparam int CW  = 16;

  logic              clk = 0;
  logic              rst_n;
  logic [NCH-1:0]    wr_en;
  logic [NCH*CW-1:0] wr_data;
  logic [2*NCH-1:0]  ld_mode;
  logic [1:0]        grp_sel;
  logic [CW-1:0]     cnt_val;
  logic [1:0]        cnt_mode;
  logic              cnt_dn;
  logic [NCH*CW-1:0] latch_val;
  logic [NCH-1:0]    eq_hit;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  logic [CW-1:0] m_reg [NCH];
  logic [CW-1:0] m_lat [NCH];
  logic m_zq, m_tq;

  cmp_latch_bank #(.NCH(NCH), .CW(CW)) u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic int lead_b(int ch, logic [1:0] g);
    if (g == 2'b01) return (ch == 0) ? 0 : ((ch % 2) == 1 ? ch : ch - 1);
    if (g == 2'b10) return (ch == 0) ? 0 : (ch <= 3 ? 1 : 4);
    if (g == 2'b11) return 1;
    return ch;
  endfunction

  function automatic logic lat_b(int ch);
    return latch_val[ch*CW +: CW];
  endfunction

  task automatic chk(string t, logic [CW-1:0] got, logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic step();
    logic zp, tp, e;
    logic [1:0] md;
    logic [CW-1:0] nlat [NCH];
    int l;
    #1;
    for (int i = 0; i < NCH; i++) begin
      chk($sformatf("%s latch ch%0d", tag, i), latch_val[i*CW +: CW], m_lat[i]);
      chk($sformatf("R2 eq ch%0d", i), CW'(eq_hit[i]), CW'(cnt_val == m_lat[i]));
    end
    zp = (cnt_val == 0) && !m_zq;
    tp = (cnt_val == m_lat[0]) && !m_tq;
    for (int i = 0; i < NCH; i++) begin
      l  = lead_b(i, grp_sel);
      md = ld_mode[2*l +: 2];
      case (md)
        2'b00: e = wr_en[i];
        2'b01: e = zp;
        2'b10: e = (cnt_mode == 2'b11) ? (tp && !cnt_dn) : zp;
        default: e = tp;
      endcase
      nlat[i] = e ? (wr_en[i] ? wr_data[i*CW +: CW] : m_reg[i]) : m_lat[i];
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin m_reg[i] = 0; m_lat[i] = 0; end
      m_zq = 1; m_tq = 1;
    end else begin
      m_zq = (cnt_val == 0);
      m_tq = (cnt_val == m_lat[0]);
      for (int i = 0; i < NCH; i++) begin
        if (wr_en[i]) m_reg[i] = wr_data[i*CW +: CW];
        m_lat[i] = nlat[i];
      end
    end
    @(negedge clk);
  endtask

  task automatic setmode(int ch, logic [1:0] m);
    ld_mode[2*ch +: 2] = m;
  endtask

  task automatic wr1(int ch, logic [CW-1:0] v);
    wr_en[ch] = 1'b1;
    wr_data[ch*CW +: CW] = v;
  endtask

  task automatic cyc(logic [CW-1:0] c);
    cnt_val = c;
    step();
    wr_en = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; wr_en = '0; wr_data = '0; ld_mode = '0; grp_sel = 2'b00;
    cnt_val = 16'd5; cnt_mode = 2'b01; cnt_dn = 0;
    for (int i = 0; i < NCH; i++) begin m_reg[i] = 0; m_lat[i] = 0; end
    m_zq = 1; m_tq = 1;
    @(negedge clk);
    step(); step();
    rst_n = 1;
    chk("R1 reset latch2", latch_val[2*CW +: CW], 16'h0);
    chk("R1 reset eq", CW'(eq_hit), 16'h0);

    // R3: immediate load, R2: equality on latch
    tag = "R3";
    wr1(2, 16'h1234); cyc(16'd5);
    chk("R3 latch2 immediate", latch_val[2*CW +: CW], 16'h1234);
    cnt_val = 16'h1234; #1;
    chk("R2 eq_hit ch2 on latch", CW'(eq_hit[2]), 16'h1);

    // R4: zero event, no repeat while held
    tag = "R4";
    setmode(3, 2'b01); cnt_mode = 2'b00;
    wr1(3, 16'h0055); cyc(16'd7);
    chk("R4 latch3 waits", latch_val[3*CW +: CW], 16'h0);
    cnt_val = 16'h0055; #1;
    chk("R2 eq ignores register", CW'(eq_hit[3]), 16'h0);
    cyc(16'd0);
    chk("R4 latch3 loaded at zero", latch_val[3*CW +: CW], 16'h0055);
    wr1(3, 16'h0066); cyc(16'd0); cyc(16'd0); cyc(16'd0);
    chk("R4 no reload while held", latch_val[3*CW +: CW], 16'h0055);
    cyc(16'd1); cyc(16'd0);
    chk("R4 reload on next zero", latch_val[3*CW +: CW], 16'h0066);

    // R6: top event at latch 0
    tag = "R6";
    wr1(0, 16'h0020); cyc(16'd3);
    setmode(4, 2'b11); wr1(4, 16'h0099); cyc(16'h0010);
    chk("R6 latch4 waits", latch_val[4*CW +: CW], 16'h0);
    cyc(16'h0020);
    chk("R6 latch4 at top", latch_val[4*CW +: CW], 16'h0099);

    // R5: split mode
    tag = "R5";
    setmode(5, 2'b10); cnt_mode = 2'b11; cnt_dn = 0;
    wr1(5, 16'h0077); cyc(16'd0);
    chk("R5 updown ignores zero", latch_val[5*CW +: CW], 16'h0);
    cnt_dn = 1; cyc(16'h0020);
    chk("R5 top ignored when down", latch_val[5*CW +: CW], 16'h0);
    cyc(16'h0005); cnt_dn = 0; cyc(16'h0020);
    chk("R5 updown loads at top", latch_val[5*CW +: CW], 16'h0077);
    cnt_mode = 2'b01; wr1(5, 16'h0078); cyc(16'h0020); cyc(16'h0003);
    chk("R5 up waits for zero", latch_val[5*CW +: CW], 16'h0077);
    cyc(16'd0);
    chk("R5 up loads at zero", latch_val[5*CW +: CW], 16'h0078);

    // R7 pairs
    tag = "R7";
    grp_sel = 2'b01; setmode(1, 2'b01); setmode(2, 2'b11);
    wr1(1, 16'h00A1); wr1(2, 16'h00A2); cyc(16'h0020);
    chk("R7 pair member waits", latch_val[2*CW +: CW], 16'h1234);
    cyc(16'd0);
    chk("R7 pair lead", latch_val[1*CW +: CW], 16'h00A1);
    chk("R9 pair member same event", latch_val[2*CW +: CW], 16'h00A2);

    // R8 triples and all
    tag = "R8";
    grp_sel = 2'b10; setmode(4, 2'b01); setmode(6, 2'b00);
    wr1(5, 16'h00B5); wr1(6, 16'h00B6); cyc(16'd9);
    chk("R8 triple member not immediate", latch_val[6*CW +: CW], 16'h0);
    cyc(16'd0);
    chk("R8 triple ch5", latch_val[5*CW +: CW], 16'h00B5);
    chk("R9 triple ch6", latch_val[6*CW +: CW], 16'h00B6);
    grp_sel = 2'b11; setmode(0, 2'b00);
    wr1(0, 16'h0030); cyc(16'd4);
    chk("R8 all-group ch0 waits", latch_val[0 +: CW], 16'h0020);
    cyc(16'd0);
    chk("R8 all-group ch0 loads", latch_val[0 +: CW], 16'h0030);

    // R10: write on load cycle
    tag = "R10";
    grp_sel = 2'b00; setmode(6, 2'b01);
    cyc(16'd2); wr1(6, 16'hBEEF); cyc(16'd0);
    chk("R10 same-cycle write captured", latch_val[6*CW +: CW], 16'hBEEF);

    // random phase
    tag = "R9";
    for (int n = 0; n < 4000; n++) begin
      if (n % 64 == 0) begin
        grp_sel  = 2'($urandom);
        ld_mode  = 14'($urandom);
        cnt_mode = 2'($urandom);
      end
      cnt_dn = 1'($urandom);
      for (int i = 0; i < NCH; i++) begin
        if ($urandom % 5 == 0) wr1(i, 16'($urandom % 48));
      end
      case ($urandom % 4)
        0: cnt_val = 0;
        1: cnt_val = m_lat[0];
        2: cnt_val = cnt_val;
        default: cnt_val = 16'($urandom % 48);
      endcase
      step();
      wr_en = '0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule